// File: doc/BRIEF.md
# External Interrupt Pin Collector

This block gathers the external interrupt pins of a small 8-bit processor. Two active-low pins are level sensitive. One active-low pin is a falling-edge, non-maskable request. A single pin-function select bit decides whether the three pins act as interrupt sources; when it is 0 they stay ordinary I/O and the block ignores them. Every pin passes through a two-flop synchronizer before the block samples it.

Each level pin owns a bit in a flag byte. A matching enable byte masks the flags, and the processor's interrupt-disable flag gates the combined maskable request. While a level pin stays low, its flag is forced to 1 on every cycle, so the request lasts until the pin is released. The edge pin latches a pending non-maskable request. That request is cleared only by an acknowledge input, and the processor's interrupt-disable flag has no effect on it. Software reads and writes the two bytes through a simple synchronous register port.

Top module: `irq_pin_unit`

## Requirements
- R1: After reset the flag byte (address 0) and the enable byte (address 1) read 0, `irq_req` and `nmi_req` are 0, and the pin-function select is taken as I/O mode.
- R2: While `pin_sel` is 0, low levels and falling edges on the three interrupt pins set no flag and raise no request.
- R3: With `pin_sel` at 1, a low level on `lvl_n[i]` sets bit i of the flag byte at the third clock edge after the pin changes. Bit positions above the level pins read 0.
- R4: `irq_req` is 1 exactly when some flag bit and the enable bit at the same position are both 1, and `cpu_iflag` is 0.
- R5: Writing the flag byte clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing the enable byte stores the low enable bits.
- R6: A clear written while a level pin is still low leaves that flag at 1.
- R7: With `pin_sel` at 1, a high-to-low transition of `nmi_n` sets `nmi_req` at the third clock edge after the pin changes, whatever the value of `cpu_iflag`.
- R8: `nmi_req` stays 1 until `nmi_ack` is sampled high. A pin held low after its edge raises no further request.
- R9: A falling edge that is detected in the same cycle as an acknowledge leaves `nmi_req` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_sel | input | 1 | 1 = pins act as interrupt sources, 0 = I/O |
| cpu_iflag | input | 1 | Processor interrupt-disable flag |
| lvl_n | input | 2 | Active-low level interrupt pins |
| nmi_n | input | 1 | Active-low falling-edge non-maskable pin |
| nmi_ack | input | 1 | Acknowledge that clears the pending non-maskable request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 flag byte, 1 enable byte |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read source: 0 flag byte, 1 enable byte |
| rd_data | output | 8 | Read data |
| irq_req | output | 1 | Maskable interrupt request |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The hardest case to reach is a new falling edge that is detected in the very cycle in which an acknowledge clears the previous request. The bench first leaves a request pending. It then raises `nmi_ack` and drops `nmi_n` on the same falling clock edge, and holds both for exactly three rising edges. The first edge clears the old request and the third detects the new edge, so `nmi_req` must read 1 once the acknowledge is released. The persistence of a level flag under a clear is reached the same way: the clear is written while the pin is still held low.

// File: rtl/irq_pin_pkg.sv
// Shared register-select encoding for the interrupt pin collector.
package irq_pin_pkg;
    typedef enum logic {
        REG_FLAG = 1'b0,
        REG_EN   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_pin_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes the inputs are idle-high pins, so the chains reset to 1.
module irq_pin_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_a,
    output logic [W-1:0] pin_s
);
    for (genvar g = 0; g < W; g++) begin : g_chain
        logic meta_q, sync_q;
        // Two-stage capture of an asynchronous pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= pin_a[g];
                sync_q <= meta_q;
            end
        end
        assign pin_s[g] = sync_q;
    end
endmodule

// File: rtl/irq_lvl_bank.sv
// Level flag and enable registers with a gated request output.
// A low pin forces its flag to 1; a clear in the same cycle loses to it.
// Assumes the pin inputs are already synchronized.
module irq_lvl_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin_sel,
    input  logic         cpu_iflag,
    input  logic [N-1:0] lvl_s_n,
    input  logic         flag_clr_we,
    input  logic         en_we,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] en_q,
    output logic         irq_req
);
    logic [N-1:0] active;
    logic [N-1:0] clr_mask;

    // Sources count only when the pins are in interrupt mode.
    always_comb active = pin_sel ? ~lvl_s_n : '0;

    // Write-one-to-clear mask.
    always_comb clr_mask = flag_clr_we ? wr_bits : '0;

    // Flag update: a held source has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | active;
    end

    // Enable register load.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wr_bits;
    end

    // Maskable request, gated by the processor flag.
    always_comb irq_req = (|(flag_q & en_q)) && !cpu_iflag;
endmodule

// File: rtl/irq_nmi_latch.sv
// Falling-edge detector with a pending latch cleared by acknowledge.
// An edge seen in the acknowledge cycle keeps the latch set.
// Assumes the pin input is already synchronized.
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sel,
    input  logic nmi_s_n,
    input  logic nmi_ack,
    output logic nmi_req
);
    logic prev_q;
    logic fall;

    // Previous synchronized level, tracked in every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= nmi_s_n;
    end

    // High-to-low transition while in interrupt mode.
    always_comb fall = pin_sel && prev_q && !nmi_s_n;

    // Pending request: set wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       nmi_req <= 1'b0;
        else if (fall)    nmi_req <= 1'b1;
        else if (nmi_ack) nmi_req <= 1'b0;
    end
endmodule

// File: rtl/irq_pin_unit.sv
// Top of the interrupt pin collector: synchronizers, level bank, edge latch
// and the register port. Assumes single-cycle register writes and reads.
module irq_pin_unit #(
    parameter int DATA_W  = 8,
    parameter int NUM_LVL = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_sel,
    input  logic               cpu_iflag,
    input  logic [NUM_LVL-1:0] lvl_n,
    input  logic               nmi_n,
    input  logic               nmi_ack,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_req,
    output logic               nmi_req
);
    import irq_pin_pkg::*;

    localparam int NPIN = NUM_LVL + 1;
    localparam int PADW = DATA_W - NUM_LVL;

    logic [NPIN-1:0]    pins_s;
    logic [NUM_LVL-1:0] flag_q, en_q;
    logic               flag_we, en_we;

    irq_pin_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_a ({nmi_n, lvl_n}),
        .pin_s (pins_s)
    );

    // Write decode.
    always_comb begin
        flag_we = wr_en && (reg_sel_e'(wr_addr) == REG_FLAG);
        en_we   = wr_en && (reg_sel_e'(wr_addr) == REG_EN);
    end

    irq_lvl_bank #(.N(NUM_LVL)) u_lvl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_sel     (pin_sel),
        .cpu_iflag   (cpu_iflag),
        .lvl_s_n     (pins_s[NUM_LVL-1:0]),
        .flag_clr_we (flag_we),
        .en_we       (en_we),
        .wr_bits     (wr_data[NUM_LVL-1:0]),
        .flag_q      (flag_q),
        .en_q        (en_q),
        .irq_req     (irq_req)
    );

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_sel (pin_sel),
        .nmi_s_n (pins_s[NUM_LVL]),
        .nmi_ack (nmi_ack),
        .nmi_req (nmi_req)
    );

    // Read mux, unused positions read zero.
    always_comb begin
        if (reg_sel_e'(rd_addr) == REG_FLAG) rd_data = {{PADW{1'b0}}, flag_q};
        else                                 rd_data = {{PADW{1'b0}}, en_q};
    end
endmodule

// File: rtl/irq_pin_unit_chk.sv
// Property checker for the interrupt pin collector, bound to every instance.
module irq_pin_unit_chk #(
    parameter int NUM_LVL = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pin_sel,
    input logic               cpu_iflag,
    input logic               nmi_ack,
    input logic               wr_en,
    input logic               irq_req,
    input logic               nmi_req,
    input logic [NUM_LVL:0]   pins_s,
    input logic [NUM_LVL-1:0] flag_q
);
    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !cpu_iflag);

    // R2
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_sel && !wr_en) |=> $stable(flag_q));

    // R6
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel && !pins_s[0]) |=> flag_q[0]);

    // R8
    nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !nmi_ack) |=> nmi_req);

    // R7
    nmi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $past(pin_sel));
endmodule

bind irq_pin_unit irq_pin_unit_chk #(.NUM_LVL(NUM_LVL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sel   (pin_sel),
    .cpu_iflag (cpu_iflag),
    .nmi_ack   (nmi_ack),
    .wr_en     (wr_en),
    .irq_req   (irq_req),
    .nmi_req   (nmi_req),
    .pins_s    (pins_s),
    .flag_q    (flag_q)
);

// File: tb/irq_pin_unit_test.sv
module irq_pin_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_sel = 1'b0, cpu_iflag = 1'b0, nmi_n = 1'b1, nmi_ack = 1'b0;
    logic [1:0] lvl_n = 2'b11;
    logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_req, nmi_req;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    irq_pin_unit uut (
        .clk(clk), .rst_n(rst_n), .pin_sel(pin_sel), .cpu_iflag(cpu_iflag),
        .lvl_n(lvl_n), .nmi_n(nmi_n), .nmi_ack(nmi_ack), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_req(irq_req), .nmi_req(nmi_req)
    );

    // Vector: {sel, iflag, lvl_n[1:0], en[1:0], exp_flags[1:0], exp_irq}
    localparam logic [8:0] VEC [6] = '{
        9'b1_0_10_01_01_1,
        9'b1_0_01_01_10_0,
        9'b1_1_00_11_11_0,
        9'b0_0_00_11_00_0,
        9'b1_0_01_10_10_1,
        9'b1_0_11_11_00_0
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        logic [7:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(1'b0, v); check("R1 flags", v, 8'h00);
        rd(1'b1, v); check("R1 enable", v, 8'h00);
        check("R1 irq", {7'd0, irq_req}, 8'h00);
        check("R1 nmi", {7'd0, nmi_req}, 8'h00);
        // R1: select is in I/O mode, so a low pin before any select does nothing
        lvl_n = 2'b10; cyc(4);
        rd(1'b0, v); check("R1 io mode", v, 8'h00);
        lvl_n = 2'b11; cyc(3);

        // Vector walk: R2 R3 R4 R5
        for (int i = 0; i < 6; i++) begin
            pin_sel = VEC[i][8]; cpu_iflag = VEC[i][7];
            wr(1'b1, {6'd0, VEC[i][4:3]});
            lvl_n = VEC[i][6:5];
            cyc(4);
            rd(1'b0, v); check("R3/R2 flags", v, {6'd0, VEC[i][2:1]});
            check("R4 irq", {7'd0, irq_req}, {7'd0, VEC[i][0]});
            lvl_n = 2'b11; cyc(4);
            wr(1'b0, 8'hFF);
            rd(1'b0, v); check("R5 clear all", v, 8'h00);
        end

        // R5: write of 0 leaves a set flag, enable readback
        pin_sel = 1'b1; cpu_iflag = 1'b0;
        lvl_n = 2'b01; cyc(4); lvl_n = 2'b11; cyc(4);
        wr(1'b0, 8'h00);
        rd(1'b0, v); check("R5 write zero keeps", v, 8'h02);
        wr(1'b0, 8'h02);
        rd(1'b0, v); check("R5 write one clears", v, 8'h00);
        wr(1'b1, 8'hFF);
        rd(1'b1, v); check("R5/R3 enable low bits only", v, 8'h03);

        // R6: clear while pin low has no lasting effect
        lvl_n = 2'b10; cyc(4);
        wr(1'b0, 8'h01);
        rd(1'b0, v); check("R6 flag persists", v, 8'h01);
        check("R6 irq persists", {7'd0, irq_req}, 8'h01);
        lvl_n = 2'b11; cyc(4);
        wr(1'b0, 8'h01);
        rd(1'b0, v); check("R6 clears after release", v, 8'h00);

        // R2: NMI edge ignored in I/O mode
        pin_sel = 1'b0;
        nmi_n = 1'b0; cyc(5);
        check("R2 nmi ignored", {7'd0, nmi_req}, 8'h00);
        nmi_n = 1'b1; cyc(4);

        // R7: edge raises request, I flag set
        pin_sel = 1'b1; cpu_iflag = 1'b1;
        nmi_n = 1'b0; cyc(2);
        check("R7 not before third edge", {7'd0, nmi_req}, 8'h00);
        cyc(1);
        check("R7 nmi raised", {7'd0, nmi_req}, 8'h01);
        // R8: held until ack, held-low pin gives nothing new
        cyc(5);
        check("R8 held", {7'd0, nmi_req}, 8'h01);
        nmi_ack = 1'b1; cyc(1); nmi_ack = 1'b0; cyc(4);
        check("R8 cleared, no repeat", {7'd0, nmi_req}, 8'h00);

        // R9: edge detected in the acknowledge cycle is kept
        nmi_n = 1'b1; cyc(4);
        nmi_n = 1'b0; cyc(4);
        check("R9 setup pending", {7'd0, nmi_req}, 8'h01);
        nmi_n = 1'b1; cyc(4);
        nmi_ack = 1'b1; nmi_n = 1'b0;
        cyc(3);
        nmi_ack = 1'b0;
        check("R9 edge kept", {7'd0, nmi_req}, 8'h01);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule